// File: doc/BRIEF.md
# PCI Target Termination Decision Unit

This unit sits inside a PCI target and settles, for every data phase of a claimed transaction, how that phase ends. A phase can finish normally, end with a retry, end with a disconnect that moves no data, or end with a disconnect that completes the current transfer. The unit drives TRDY# and STOP# (both active low) to match its choice. It also reports the choice as a two-bit code.

Its inputs are the target's status conditions:
- lock ownership by another master;
- posting-buffer room for writes and posting-buffer flush state for reads;
- whether the buffer is about to fill;
- whether the burst has reached a resource boundary;
- whether prefetch is enabled;
- the transaction direction.

The initial and subsequent latency limits are tracked internally with one wait counter. Address decoding, data movement and master behaviour lie outside the unit. The unit assumes the master keeps IRDY# asserted, so a phase completes in any cycle where TRDY# is low.

Top module: `pciTermUnit`

## Requirements
- R1: After reset, and while no transaction is claimed, trdyN and stopN are high and termCode is 0. The termCode encoding is 0 = normal, 1 = retry, 2 = disconnect without data, 3 = disconnect with data.
- R2: A transaction starts on a cycle with addrHit high and frameN low. In its data phases, when no termination condition holds, trdyN is low exactly in the cycles where dataReady is high, and stopN stays high. A phase that completes while frameN is high ends the transaction.
- R3: On the first data phase only, each of the following gives a retry: lockedOther high, a write with postAvail low, or a read with postFlushed low. A retry drives stopN low, trdyN high and termCode 1.
- R4: If dataReady is still low in the INIT_LIMIT-th data cycle of the first phase (default 16 clocks after the address phase), that cycle is a retry. The cycle before it is still a plain wait.
- R5: On a later data phase, either of the following gives a disconnect without data: dataReady still low in the SUB_LIMIT-th cycle of that phase (default 8), or a write with postAvail low. This drives stopN low, trdyN high and termCode 2.
- R6: With dataReady high on any phase, a disconnect with data is given when any of the following holds: atBoundary is high, a read has prefetchEn low, or a write has postLast high. This drives both stopN and trdyN low and termCode 3.
- R7: When conditions of more than one kind hold at once, retry wins over disconnect without data, which wins over disconnect with data. Termination code 2 never appears on the first phase.
- R8: Once stopN is low it stays low, with trdyN high and termCode 0, while frameN stays low. It returns high on the clock after a cycle in which stopN was low and frameN was high.
- R9: The direction is taken from isWrite in the address phase only. Changes on isWrite during the data phases have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | FRAME# from the bus, active low |
| addrHit | input | 1 | Address phase claims this target |
| isWrite | input | 1 | Direction of the transaction, sampled in the address phase |
| dataReady | input | 1 | Target can source or sink data this cycle |
| lockedOther | input | 1 | Target is locked by a different master |
| postAvail | input | 1 | Posting buffers have room (writes) |
| postLast | input | 1 | Posting buffers fill with this write phase |
| postFlushed | input | 1 | Posting buffers are flushed (reads) |
| atBoundary | input | 1 | Current phase is the last before the resource boundary |
| prefetchEn | input | 1 | Prefetch is enabled for reads |
| trdyN | output | 1 | TRDY#, active low |
| stopN | output | 1 | STOP#, active low |
| termCode | output | 2 | Termination chosen this cycle (0 normal, 1 retry, 2 no-data disconnect, 3 data disconnect) |

## Verification
The assertions take several things for granted about the inputs:
- the master never stalls with IRDY#;
- once frameN rises inside a transaction, it stays high until that transaction ends;
- addrHit is raised only in an idle cycle with frameN low.

The stimulus generator follows the bench's own model of the transaction state, so it keeps to these rules. It raises frameN only once per transaction, raises addrHit only when the model is idle, and otherwise randomises the status conditions freely. Directed cases add exact latency runs and stacks of simultaneous conditions.

// File: rtl/ttdPkg.sv
package ttdPkg;

  typedef enum logic [1:0] {
    TERM_NONE        = 2'd0,
    TERM_RETRY       = 2'd1,
    TERM_DISC_NODATA = 2'd2,
    TERM_DISC_DATA   = 2'd3
  } termKindE;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2
  } ctlStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic startTxn;  // address phase claimed
    logic dataDone;  // current data phase completes
    logic waitTick;  // data phase waits one more clock
  } dpStrobeS;

endpackage

// File: rtl/ttdDatapath.sv
module ttdDatapath
  import ttdPkg::*;
#(
  parameter int INIT_LIMIT = 16,
  parameter int SUB_LIMIT  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpStrobeS strobe,
  input  logic     isWrite,
  output logic     firstPhase,
  output logic     wrLatched,
  output logic     initExpiring,
  output logic     subExpiring
);

  localparam int MAX_LIMIT = (INIT_LIMIT > SUB_LIMIT) ? INIT_LIMIT : SUB_LIMIT;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_LIMIT - 1);
  localparam logic [CNT_W-1:0] SUB_LAST  = CNT_W'(SUB_LIMIT - 1);

  logic [CNT_W-1:0] waitCnt;
  logic             firstQ;
  logic             wrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      firstQ  <= 1'b0;
      wrQ     <= 1'b0;
    end else if (strobe.startTxn) begin
      waitCnt <= '0;
      firstQ  <= 1'b1;
      wrQ     <= isWrite;
    end else if (strobe.dataDone) begin
      waitCnt <= '0;
      firstQ  <= 1'b0;
    end else if (strobe.waitTick) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign firstPhase   = firstQ;
  assign wrLatched    = wrQ;
  assign initExpiring = firstQ && (waitCnt == INIT_LAST);
  assign subExpiring  = !firstQ && (waitCnt == SUB_LAST);

  // the control must end a phase before the wait count passes its limit
  AST_INIT_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    firstQ |-> (waitCnt <= INIT_LAST)); // R4
  AST_SUB_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !firstQ |-> (waitCnt <= SUB_LAST)); // R5

endmodule

// File: rtl/ttdControl.sv
module ttdControl
  import ttdPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameN,
  input  logic     addrHit,
  input  logic     dataReady,
  input  logic     lockedOther,
  input  logic     postAvail,
  input  logic     postLast,
  input  logic     postFlushed,
  input  logic     atBoundary,
  input  logic     prefetchEn,
  input  logic     firstPhase,
  input  logic     wrLatched,
  input  logic     initExpiring,
  input  logic     subExpiring,
  output logic     trdyN,
  output logic     stopN,
  output termKindE termKind,
  output dpStrobeS strobe
);

  ctlStateE state, stateNext;

  logic bufBlocked, initTimeout, subTimeout;
  logic wantRetry, wantNoData, wantWithData;

  always_comb begin
    bufBlocked   = wrLatched ? !postAvail : !postFlushed;
    initTimeout  = initExpiring && !dataReady;
    subTimeout   = subExpiring && !dataReady;
    wantRetry    = firstPhase && (lockedOther || bufBlocked || initTimeout);
    wantNoData   = !firstPhase && (subTimeout || (wrLatched && !postAvail));
    wantWithData = dataReady && (atBoundary || (!wrLatched && !prefetchEn) ||
                                 (wrLatched && postLast));
  end

  always_comb begin
    termKind = TERM_NONE;
    trdyN    = 1'b1;
    stopN    = 1'b1;
    strobe   = '0;
    case (state)
      ST_IDLE: strobe.startTxn = addrHit && !frameN;
      ST_DATA: begin
        if (wantRetry)         termKind = TERM_RETRY;
        else if (wantNoData)   termKind = TERM_DISC_NODATA;
        else if (wantWithData) termKind = TERM_DISC_DATA;
        case (termKind)
          TERM_RETRY, TERM_DISC_NODATA: stopN = 1'b0;
          TERM_DISC_DATA: begin
            stopN = 1'b0;
            trdyN = 1'b0;
          end
          default: trdyN = !dataReady;
        endcase
        strobe.dataDone = !trdyN;
        strobe.waitTick = trdyN && stopN;
      end
      ST_HOLD: stopN = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.startTxn) stateNext = ST_DATA;
      ST_DATA: begin
        if (!stopN)                stateNext = frameN ? ST_IDLE : ST_HOLD;
        else if (!trdyN && frameN) stateNext = ST_IDLE;
      end
      ST_HOLD: if (frameN) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (trdyN && stopN && termKind == TERM_NONE)); // R1
  AST_RETRY_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (termKind == TERM_RETRY) |-> (firstPhase && trdyN && !stopN)); // R3
  AST_NODATA_LATER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (termKind == TERM_DISC_NODATA) |-> (!firstPhase && trdyN && !stopN)); // R7
  AST_WITHDATA_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (termKind == TERM_DISC_DATA) |-> (!trdyN && !stopN && dataReady)); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> (!stopN && trdyN)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && frameN) |=> stopN); // R8

endmodule

// File: rtl/pciTermUnit.sv
module pciTermUnit
  import ttdPkg::*;
#(
  parameter int INIT_LIMIT = 16,
  parameter int SUB_LIMIT  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       addrHit,
  input  logic       isWrite,
  input  logic       dataReady,
  input  logic       lockedOther,
  input  logic       postAvail,
  input  logic       postLast,
  input  logic       postFlushed,
  input  logic       atBoundary,
  input  logic       prefetchEn,
  output logic       trdyN,
  output logic       stopN,
  output logic [1:0] termCode
);

  dpStrobeS strobe;
  termKindE termKind;
  logic     firstPhase, wrLatched, initExpiring, subExpiring;

  ttdDatapath #(.INIT_LIMIT(INIT_LIMIT), .SUB_LIMIT(SUB_LIMIT)) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .isWrite      (isWrite),
    .firstPhase   (firstPhase),
    .wrLatched    (wrLatched),
    .initExpiring (initExpiring),
    .subExpiring  (subExpiring)
  );

  ttdControl uControl (
    .clk          (clk),
    .rstN         (rstN),
    .frameN       (frameN),
    .addrHit      (addrHit),
    .dataReady    (dataReady),
    .lockedOther  (lockedOther),
    .postAvail    (postAvail),
    .postLast     (postLast),
    .postFlushed  (postFlushed),
    .atBoundary   (atBoundary),
    .prefetchEn   (prefetchEn),
    .firstPhase   (firstPhase),
    .wrLatched    (wrLatched),
    .initExpiring (initExpiring),
    .subExpiring  (subExpiring),
    .trdyN        (trdyN),
    .stopN        (stopN),
    .termKind     (termKind),
    .strobe       (strobe)
  );

  assign termCode = termKind;

endmodule

// File: tb/tb_pciTermUnit.sv
module tb_pciTermUnit;

  localparam int INIT_LIMIT = 16;
  localparam int SUB_LIMIT  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, addrHit = 1'b0, isWrite = 1'b0, dataReady = 1'b0;
  logic lockedOther = 1'b0, postAvail = 1'b1, postLast = 1'b0, postFlushed = 1'b1;
  logic atBoundary = 1'b0, prefetchEn = 1'b1;
  logic trdyN, stopN;
  logic [1:0] termCode;

  pciTermUnit #(.INIT_LIMIT(INIT_LIMIT), .SUB_LIMIT(SUB_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .addrHit(addrHit), .isWrite(isWrite),
    .dataReady(dataReady), .lockedOther(lockedOther), .postAvail(postAvail),
    .postLast(postLast), .postFlushed(postFlushed), .atBoundary(atBoundary),
    .prefetchEn(prefetchEn), .trdyN(trdyN), .stopN(stopN), .termCode(termCode)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model of the transaction, built from the requirements
  int mState = 0;   // 0 idle, 1 data, 2 stop held
  bit mFirst = 0, mWr = 0, mPrevStop = 0;
  int mCnt = 0;
  bit eTrdy = 1, eStop = 1;
  int eCode = 0;

  function automatic string expect_outputs();
    bit bufBad, retry, noData, withData, initTo, subTo;
    int kinds;
    eTrdy = 1; eStop = 1; eCode = 0;
    if (mState == 2) begin
      eStop = 0;
      return "R8";
    end
    if (mState == 0) return mPrevStop ? "R8" : "R2";
    bufBad   = mWr ? !postAvail : !postFlushed;
    initTo   = mFirst && (mCnt == INIT_LIMIT - 1) && !dataReady;
    subTo    = !mFirst && (mCnt == SUB_LIMIT - 1) && !dataReady;
    retry    = mFirst && (lockedOther || bufBad || initTo);
    noData   = !mFirst && (subTo || (mWr && !postAvail));
    withData = dataReady && (atBoundary || (!mWr && !prefetchEn) || (mWr && postLast));
    kinds = int'(retry) + int'(noData) + int'(withData);
    if (retry)         begin eCode = 1; eStop = 0; end
    else if (noData)   begin eCode = 2; eStop = 0; end
    else if (withData) begin eCode = 3; eStop = 0; eTrdy = 0; end
    else               eTrdy = !dataReady;
    if (kinds > 1) return "R7";
    if (retry) return (initTo && !lockedOther && !bufBad) ? "R4" : "R3";
    if (noData) return "R5";
    if (withData) return "R6";
    return "R2";
  endfunction

  function automatic void update_model();
    mPrevStop = !eStop;
    case (mState)
      0: if (addrHit && !frameN) begin
           mState = 1; mFirst = 1; mCnt = 0; mWr = isWrite;
         end
      1: if (!eStop) mState = frameN ? 0 : 2;
         else if (!eTrdy) begin
           if (frameN) mState = 0;
           else begin mFirst = 0; mCnt = 0; end
         end else mCnt++;
      default: if (frameN) mState = 0;
    endcase
  endfunction

  // called at a falling edge with inputs settled
  task automatic tick(input string tagOverride);
    string tag;
    #1;
    tag = expect_outputs();
    if (tagOverride != "") tag = tagOverride;
    nChecks++;
    if (trdyN !== eTrdy || stopN !== eStop || int'(termCode) != eCode) begin
      nFails++;
      $display("FAIL %s: trdyN/stopN/termCode actual %b/%b/%0d expected %b/%b/%0d",
               tag, trdyN, stopN, termCode, eTrdy, eStop, eCode);
    end
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic benign();
    lockedOther = 0; postAvail = 1; postLast = 0; postFlushed = 1;
    atBoundary = 0; prefetchEn = 1; dataReady = 1;
  endtask

  task automatic start_txn(input bit wr);
    benign();
    frameN = 0; addrHit = 1; isWrite = wr;
    tick("R2");
    addrHit = 0;
  endtask

  task automatic end_txn();
    frameN = 1;
    for (int i = 0; i < 40 && mState != 0; i++) tick("");
    benign();
    tick("");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    nChecks++;
    if (trdyN !== 1'b1 || stopN !== 1'b1 || termCode !== 2'd0) begin
      nFails++;
      $display("FAIL R1: reset trdyN/stopN/termCode actual %b/%b/%0d expected 1/1/0",
               trdyN, stopN, termCode);
    end
    @(negedge clk);
    rstN = 1;
    tick("R1");

    // R2 normal read burst with a wait cycle
    start_txn(0);
    tick("R2");
    dataReady = 0; tick("R2");
    dataReady = 1; tick("R2");
    end_txn();

    // R3 locked by another master, stop held then released (R8)
    start_txn(0);
    lockedOther = 1; tick("R3");
    lockedOther = 0; tick("R8"); tick("R8");
    end_txn();

    // R3 write without buffer room; read not flushed
    start_txn(1);
    postAvail = 0; tick("R3");
    end_txn();
    start_txn(0);
    postFlushed = 0; tick("R3");
    end_txn();

    // R4 initial latency: waits up to the limit, retry on the last cycle
    start_txn(0);
    dataReady = 0;
    for (int i = 0; i < INIT_LIMIT; i++) tick(i == INIT_LIMIT - 1 ? "R4" : "R2");
    end_txn();

    // R5 subsequent latency and write buffer loss on a later phase
    start_txn(0);
    tick("R2");
    dataReady = 0;
    for (int i = 0; i < SUB_LIMIT; i++) tick(i == SUB_LIMIT - 1 ? "R5" : "R2");
    end_txn();
    start_txn(1);
    tick("R2");
    postAvail = 0; tick("R5");
    end_txn();

    // R6 disconnect with data: boundary, read without prefetch, write filling buffer
    start_txn(0);
    atBoundary = 1; tick("R6");
    end_txn();
    start_txn(0);
    prefetchEn = 0; tick("R6");
    end_txn();
    start_txn(1);
    tick("R2");
    postLast = 1; tick("R6");
    end_txn();

    // R7 priorities
    start_txn(0);
    lockedOther = 1; atBoundary = 1; tick("R7");
    end_txn();
    start_txn(1);
    tick("R2");
    postAvail = 0; atBoundary = 1; tick("R7");
    end_txn();

    // R9 direction latched: a read ignores isWrite and postAvail later on
    start_txn(0);
    tick("R2");
    isWrite = 1; postAvail = 0; tick("R9");
    end_txn();

    // constrained random traffic
    void'($urandom(32'h1a2b3c4d));
    for (int n = 0; n < 4000; n++) begin
      if (mState == 0) begin
        if ($urandom % 4 == 0) begin
          frameN = 0; addrHit = 1; isWrite = 1'($urandom % 2);
        end else begin
          frameN = 1; addrHit = 0;
        end
      end else begin
        addrHit = 0;
        isWrite = 1'($urandom % 2);
        if (frameN == 0 && $urandom % 6 == 0) frameN = 1;
      end
      lockedOther = ($urandom % 16 == 0);
      postAvail   = ($urandom % 8 != 0);
      postLast    = ($urandom % 8 == 0);
      postFlushed = ($urandom % 6 != 0);
      atBoundary  = ($urandom % 10 == 0);
      prefetchEn  = ($urandom % 4 != 0);
      dataReady   = ($urandom % 3 != 0);
      tick("");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule